// File: doc/BRIEF.md
# Windowed First-Edge Time Encoder

This block converts the sampled history of a timing comparator into a 6-bit arrival-time code. It does this once per 25 ns measurement window, and the windows follow one another at 40 MHz with no dead time between them. Upstream logic captures the comparator output at every 500 ps delay-line tap. It presents the whole window as one vector, together with a flag that says whether the delay line is locked. The comparison threshold is programmed upstream, so this block only ever sees comparator bits.

On each window strobe the block finds the first tap where the comparator goes from low to high. The comparison with the tap before it includes the last tap of the previous window, which is held in a one-bit history register. The block reports the index of that tap as a time code from 0 to 49. Three codes at the top of the 6-bit space report the cases that carry no time:
- 61: the delay line is not locked.
- 62: the input stayed above the threshold for the whole window.
- 63: the window holds no rising crossing.

Each result carries a two-bit capacitor ID, which tags the window with its slot in a four-phase rotating pipeline.

Top module: `tdc_window_encoder`

## Requirements
- R1: A synchronous active-high reset clears `code_valid` to 0, clears the capacitor-ID counter so that the first result after reset is tagged 0, and clears the history bit to low.
- R2: `code_valid` is 1 in exactly the cycle after each cycle in which `win_strobe` is sampled high, and is 0 otherwise. Back-to-back strobes give back-to-back results.
- R3: When `dll_locked` is 0 on a strobe, the code is 61, whatever the taps hold.
- R4: When the lock is good, all taps are high and the previous window's last tap was high, the code is 62.
- R5: When the lock is good, all taps are high and the previous window's last tap was low, the code is 0 (a crossing at tap 0).
- R6: When the lock is good and all taps are low, the code is 63.
- R7: Otherwise, when the lock is good, the code is the smallest index i (0..NTAPS-1) where tap i is high and tap i-1 is low. Tap -1 is the previous window's last tap.
- R8: A locked window that is neither all high nor all low but contains no low-to-high change (the input only falls) gives code 63.
- R9: Each result is tagged with the capacitor-ID value current at its strobe. The counter then advances by one, wrapping from 3 to 0.
- R10: The history bit takes tap NTAPS-1 on every strobe, including strobes on which the delay line is unlocked.
- R11: Between strobes `tdc_code` and `cap_id` hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| win_strobe | input | 1 | Window boundary: `taps` and `dll_locked` hold a complete window |
| dll_locked | input | 1 | Delay line locked when 1 |
| taps | input | NTAPS (50) | Comparator sample per tap; bit 0 is earliest |
| tdc_code | output | 6 | Time code 0..NTAPS-1, or 61/62/63 |
| cap_id | output | 2 | Capacitor ID of the reported window |
| code_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
Every result is due one clock after its strobe, because `win_strobe`, `taps` and `dll_locked` pass through a single register stage. The bench applies inputs on a falling edge and reads the outputs on the next falling edge, half a cycle after the rising edge that loads them. On idle cycles between windows it checks at that same point that the valid strobe is low and that the code and ID have not moved. The bench model carries its own copy of the history bit and the capacitor ID from window to window, so it always predicts a window from the one before it.

// File: rtl/tdc_enc_pkg.sv
package tdc_enc_pkg;

  localparam int CODE_W  = 6;
  localparam int CAPID_W = 2;

  localparam logic [CODE_W-1:0] CODE_NOLOCK = 6'd61;
  localparam logic [CODE_W-1:0] CODE_ALLHI  = 6'd62;
  localparam logic [CODE_W-1:0] CODE_NOEDGE = 6'd63;

  typedef enum logic [1:0] {
    WK_TIME   = 2'd0,
    WK_NOLOCK = 2'd1,
    WK_ALLHI  = 2'd2,
    WK_NOEDGE = 2'd3
  } win_kind_e;

  // Map a window classification and a tap index to the output code.
  function automatic logic [CODE_W-1:0] kind_to_code(input win_kind_e k,
                                                     input logic [CODE_W-1:0] t);
    case (k)
      WK_NOLOCK: return CODE_NOLOCK;
      WK_ALLHI:  return CODE_ALLHI;
      WK_NOEDGE: return CODE_NOEDGE;
      default:   return t;
    endcase
  endfunction

  // Next capacitor ID: wraps modulo the phase count.
  function automatic logic [CAPID_W-1:0] capid_next(input logic [CAPID_W-1:0] c);
    return c + CAPID_W'(1);
  endfunction

endpackage

// File: rtl/tdc_rise_detect.sv
module tdc_rise_detect #(
  parameter int NTAPS = 50
) (
  input  logic [NTAPS-1:0] taps,
  input  logic             prev_last,
  output logic [NTAPS-1:0] rise
);
  // Tap 0 compares against the previous window's final tap.
  assign rise[0] = taps[0] & ~prev_last;

  for (genvar i = 1; i < NTAPS; i++) begin : g_rise
    assign rise[i] = taps[i] & ~taps[i-1];
  end
endmodule

// File: rtl/tdc_first_index.sv
module tdc_first_index #(
  parameter int NTAPS = 50,
  parameter int IDX_W = $clog2(NTAPS)
) (
  input  logic [NTAPS-1:0] rise,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top so the lowest set bit wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NTAPS - 1; i >= 0; i--) begin
      if (rise[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tdc_code_select.sv
module tdc_code_select
  import tdc_enc_pkg::*;
#(
  parameter int NTAPS = 50,
  parameter int IDX_W = $clog2(NTAPS)
) (
  input  logic [NTAPS-1:0]  taps,
  input  logic              locked,
  input  logic              prev_last,
  input  logic              found,
  input  logic [IDX_W-1:0]  idx,
  output win_kind_e         kind,
  output logic [CODE_W-1:0] code
);
  logic all_hi;
  assign all_hi = &taps;

  // Priority: lock fault, held-high, first crossing, no crossing.
  always_comb begin
    if (!locked)                 kind = WK_NOLOCK;
    else if (all_hi && prev_last) kind = WK_ALLHI;
    else if (found)              kind = WK_TIME;
    else                         kind = WK_NOEDGE;
  end

  assign code = kind_to_code(kind, CODE_W'(idx));
endmodule

// File: rtl/tdc_phase_counter.sv
module tdc_phase_counter
  import tdc_enc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  output logic [CAPID_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (adv) phase <= capid_next(phase);
  end
endmodule

// File: rtl/tdc_window_encoder.sv
module tdc_window_encoder
  import tdc_enc_pkg::*;
#(
  parameter int NTAPS = 50
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               win_strobe,
  input  logic               dll_locked,
  input  logic [NTAPS-1:0]   taps,
  output logic [CODE_W-1:0]  tdc_code,
  output logic [CAPID_W-1:0] cap_id,
  output logic               code_valid
);
  localparam int IDX_W = $clog2(NTAPS);

  // Named internal events, visible to the bound checker.
  logic               hist_q;
  logic [NTAPS-1:0]   rise_vec;
  logic               first_found;
  logic [IDX_W-1:0]   first_idx;
  win_kind_e          win_kind;
  logic [CODE_W-1:0]  next_code;
  logic [CAPID_W-1:0] cap_cnt;

  tdc_rise_detect #(.NTAPS(NTAPS)) u_rise (
    .taps      (taps),
    .prev_last (hist_q),
    .rise      (rise_vec)
  );

  tdc_first_index #(.NTAPS(NTAPS), .IDX_W(IDX_W)) u_first (
    .rise  (rise_vec),
    .found (first_found),
    .idx   (first_idx)
  );

  tdc_code_select #(.NTAPS(NTAPS), .IDX_W(IDX_W)) u_sel (
    .taps      (taps),
    .locked    (dll_locked),
    .prev_last (hist_q),
    .found     (first_found),
    .idx       (first_idx),
    .kind      (win_kind),
    .code      (next_code)
  );

  tdc_phase_counter u_phase (
    .clk   (clk),
    .rst   (rst),
    .adv   (win_strobe),
    .phase (cap_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q     <= 1'b0;
      code_valid <= 1'b0;
      tdc_code   <= CODE_NOEDGE;
      cap_id     <= '0;
    end else begin
      code_valid <= win_strobe;
      if (win_strobe) begin
        hist_q   <= taps[NTAPS-1];
        tdc_code <= next_code;
        cap_id   <= cap_cnt;
      end
    end
  end
endmodule

// File: rtl/tdc_window_encoder_chk.sv
module tdc_window_encoder_chk
  import tdc_enc_pkg::*;
#(
  parameter int NTAPS = 50
) (
  input logic               clk,
  input logic               rst,
  input logic               win_strobe,
  input logic               dll_locked,
  input logic [NTAPS-1:0]   taps,
  input logic [CODE_W-1:0]  tdc_code,
  input logic [CAPID_W-1:0] cap_id,
  input logic               code_valid,
  input logic               hist_q,
  input logic [CAPID_W-1:0] cap_cnt
);
  // R2
  valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    win_strobe |=> code_valid);
  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !win_strobe |=> !code_valid);
  // R3
  nolock_code_chk: assert property (@(posedge clk) disable iff (rst)
    (win_strobe && !dll_locked) |=> tdc_code == CODE_NOLOCK);
  // R4
  held_high_chk: assert property (@(posedge clk) disable iff (rst)
    (win_strobe && dll_locked && (&taps) && hist_q) |=> tdc_code == CODE_ALLHI);
  // R5
  tap0_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (win_strobe && dll_locked && taps[0] && !hist_q) |=> tdc_code == '0);
  // R6
  all_low_chk: assert property (@(posedge clk) disable iff (rst)
    (win_strobe && dll_locked && taps == '0) |=> tdc_code == CODE_NOEDGE);
  // R7
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    code_valid |-> (int'(tdc_code) < NTAPS || tdc_code >= CODE_NOLOCK));
  // R9
  capid_advance_chk: assert property (@(posedge clk) disable iff (rst)
    win_strobe |=> cap_cnt == CAPID_W'($past(cap_cnt) + CAPID_W'(1)));
  // R9
  capid_tag_chk: assert property (@(posedge clk) disable iff (rst)
    code_valid |-> cap_id == CAPID_W'(cap_cnt - CAPID_W'(1)));
  // R10
  history_load_chk: assert property (@(posedge clk) disable iff (rst)
    win_strobe |=> hist_q == $past(taps[NTAPS-1]));
  // R11
  hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !win_strobe |=> ($stable(tdc_code) && $stable(cap_id) && $stable(cap_cnt)));
endmodule

bind tdc_window_encoder tdc_window_encoder_chk #(.NTAPS(NTAPS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .win_strobe (win_strobe),
  .dll_locked (dll_locked),
  .taps       (taps),
  .tdc_code   (tdc_code),
  .cap_id     (cap_id),
  .code_valid (code_valid),
  .hist_q     (hist_q),
  .cap_cnt    (cap_cnt)
);

// File: tb/test_tdc_window_encoder.sv
module test_tdc_window_encoder;
  localparam int CLK_P = 10;
  localparam int NT    = 50;

  logic          clk = 1'b0;
  logic          rst;
  logic          win_strobe;
  logic          dll_locked;
  logic [NT-1:0] taps;
  logic [5:0]    tdc_code;
  logic [1:0]    cap_id;
  logic          code_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic       m_hist;
  logic [1:0] m_cap;
  logic [5:0] last_code;
  logic [1:0] last_cap;

  always #(CLK_P/2) clk = ~clk;

  tdc_window_encoder #(.NTAPS(NT)) i_tdc_window_encoder (
    .clk(clk), .rst(rst), .win_strobe(win_strobe), .dll_locked(dll_locked),
    .taps(taps), .tdc_code(tdc_code), .cap_id(cap_id), .code_valid(code_valid)
  );

  // Reference: walk the taps carrying the previous level along.
  function automatic logic [5:0] ref_code(input logic [NT-1:0] t,
                                          input logic lk, input logic h);
    logic prev;
    if (!lk) return 6'd61;
    prev = h;
    for (int i = 0; i < NT; i++) begin
      if (t[i] && !prev) return 6'(i);
      prev = t[i];
    end
    if (t == {NT{1'b1}}) return 6'd62;
    return 6'd63;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; applies one window and checks its result.
  task automatic run_win(input logic [NT-1:0] t, input logic lk, input string req);
    logic [5:0] ec;
    logic [1:0] ecap;
    taps = t; dll_locked = lk; win_strobe = 1'b1;
    ec = ref_code(t, lk, m_hist);
    ecap = m_cap;
    m_hist = t[NT-1];
    m_cap = m_cap + 2'd1;
    @(negedge clk);
    win_strobe = 1'b0;
    check({req, " R2 valid"}, int'(code_valid), 1);
    check({req, " code"}, int'(tdc_code), int'(ec));
    check({req, " R9 cap_id"}, int'(cap_id), int'(ecap));
    last_code = ec;
    last_cap = ecap;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      taps = NT'({$urandom, $urandom});
      dll_locked = $urandom % 2 == 0;
      @(negedge clk);
      check("R2 idle valid", int'(code_valid), 0);
      check("R11 hold code", int'(tdc_code), int'(last_code));
      check("R11 hold cap_id", int'(cap_id), int'(last_cap));
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NT-1:0] t;
    logic [NT-1:0] ones;
    void'($urandom(32'd20240611));
    ones = '1;
    rst = 1'b1; win_strobe = 1'b1; dll_locked = 1'b1; taps = '0;
    m_hist = 1'b0; m_cap = 2'd0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(code_valid), 0);
    win_strobe = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 no valid after reset", int'(code_valid), 0);

    run_win(ones, 1'b1, "R1 R5 first all-high");       // 0, tag 0
    run_win(ones, 1'b1, "R4 held high");                // 62
    t = '0; t[1:0] = 2'b11;
    run_win(t, 1'b1, "R8 falling only");                // 63
    run_win('0, 1'b1, "R6 all low");                    // 63
    t = '0; t[NT-1] = 1'b1; t[7] = 1'b1;
    run_win(t, 1'b0, "R3 unlocked");                    // 61, hist <- 1
    run_win(ones, 1'b1, "R10 history after unlock");    // 62
    t = '0; t[NT-1] = 1'b1;
    run_win(t, 1'b1, "R7 last tap crossing");           // 49
    t = '0; t[5] = 1'b1; t[20] = 1'b1;
    run_win(t, 1'b1, "R7 two pulses");                  // 5
    idle(2);

    for (int w = 0; w < 400; w++) begin
      int kind, p, q;
      kind = int'($urandom % 5);
      p = int'($urandom % NT);
      q = int'($urandom % NT);
      case (kind)
        0: t = NT'({$urandom, $urandom});
        1: t = ones << p;
        2: t = ones;
        3: t = '0;
        default: t = (ones << p) & ~(ones << q);
      endcase
      run_win(t, ($urandom % 8) != 0, "R7 random");
      if ($urandom % 3 == 0) idle(int'($urandom % 3) + 1);
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 valid after mid reset", int'(code_valid), 0);
    m_hist = 1'b0; m_cap = 2'd0;
    run_win(ones, 1'b1, "R1 history cleared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule